// File: doc/BRIEF.md
# Flexible TDM Byte-Slot Output Mapper

This block turns a bank of 24 parallel audio channels into two serial TDM output streams. Each stream carries a frame of 32 byte-wide slots, 256 bits per frame. A per-slot selection field picks a source channel and one of its three bytes. A 16-bit configuration word holds the fields for two neighbouring slots. A channel may therefore be 8, 16 or 24 bits wide on the line and take one, two or three slots. Those slots need not be adjacent, but their byte order must run from most to least significant as the slot number rises.

On each frame-sync pulse the block latches the whole frame from the channel bank into a shift register for each port. It then shifts the frame out MSB-first, one bit per clock. The clock is the bit clock. Any slot with an illegal selection outputs zero and sets a sticky error flag. A port whose word-length selection is not the flexible setting outputs zero.

Top module: `flex_tdm_mapper`

## Requirements
- R1: A write with `cfg_we_i` high stores `cfg_wdata_i` in pair word `cfg_addr_i`. Bits [7:0] select for global slot 2*addr and bits [15:8] select for global slot 2*addr+1. Global slots 0–31 are slots 0–31 of port 0, and global slots 32–63 are slots 0–31 of port 1.
- R2: In a slot field, bits [7:2] are the channel index and bits [1:0] are the byte select. Byte select 00 gives channel bits [23:16], 01 gives bits [15:8] and 10 gives bits [7:0]. Channel c occupies `chan_data_i[24*c+23 : 24*c]`.
- R3: When `fsync_i` is high at a rising clock edge, the frame is loaded. After that edge, `sdata_o[p]` carries bit 7 of slot 0 of port p. Bit b of slot k appears 8*k+(7-b) clock cycles after the load edge.
- R4: Once the 256 frame bits have been sent, the output stays 0 until the next load. A load in the middle of a frame restarts the frame from slot 0.
- R5: A field of 0xFF marks the slot unused, and the slot outputs zero without an error. After reset, every pair word is 0xFFFF.
- R6: Port p is in flexible mode only when `wl_sel_i[2p+1:2p]` is 2'b11. In any other setting, the port outputs zero and its slots raise no error.
- R7: A channel index above 23 makes that slot output zero and is an error.
- R8: A used slot whose channel appears in an earlier used slot of the same port, with a byte select equal to or later than its own, outputs zero and is an error. Byte select 11 is also an error. Slots of one channel in rising byte order may have gaps between them.
- R9: The last slot of each port (global slots 31 and 63) may use only byte select 00. Any other byte select there outputs zero and is an error.
- R10: `config_error_o` is 0 after reset. It rises in the cycle after a load edge at which a flexible port holds an error slot. It then stays high until reset.
- R11: A change to `chan_data_i` after the load edge does not change the frame being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Pair word write strobe |
| cfg_addr_i | input | 5 | Pair word index |
| cfg_wdata_i | input | 16 | Pair word write data |
| wl_sel_i | input | 4 | Word-length selection, two bits per port |
| chan_data_i | input | 576 | Channel bank, 24 channels of 24 bits |
| fsync_i | input | 1 | Frame sync pulse, loads a new frame |
| sdata_o | output | 2 | Serial data, one bit per port |
| config_error_o | output | 1 | Sticky illegal-configuration flag |

## Verification
The hardest case to reach from the ports is an ordering error. It depends on the relation between two slot fields that may sit in different pair words. It must also be told apart from a legal split channel whose bytes have gaps between them. The bench first builds legal non-adjacent layouts, including a lone least-significant byte and a most-significant byte in the last slot, and checks that no error appears. After a reset, it writes one pair in which the later slot repeats an earlier byte of the same channel. It then checks that only the later slot goes to zero while the flag rises.

// File: rtl/flex_tdm_pkg.sv
package flex_tdm_pkg;
  typedef struct packed {
    logic [5:0] chan;
    logic [1:0] bsel;
  } slot_sel_t;

  localparam logic [1:0] BSEL_MS   = 2'b00;
  localparam logic [1:0] BSEL_BAD  = 2'b11;
  localparam logic [1:0] WL_FLEX   = 2'b11;
  localparam logic [7:0] SLOT_IDLE = 8'hFF;
endpackage

// File: rtl/tdm_slot_cfg.sv
module tdm_slot_cfg
  import flex_tdm_pkg::*;
#(
  parameter int N_PAIRS = 32,
  localparam int AW = $clog2(N_PAIRS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [15:0]               wdata_i,
  output slot_sel_t [2*N_PAIRS-1:0] slot_cfg_o
);
  logic [15:0] pair_q [N_PAIRS];

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        pair_q[p] <= 16'hFFFF;
      else if (we_i && addr_i == AW'(p))  pair_q[p] <= wdata_i;
    end
    // low byte -> even slot, high byte -> odd slot
    assign slot_cfg_o[2*p]   = pair_q[p][7:0];
    assign slot_cfg_o[2*p+1] = pair_q[p][15:8];
  end
endmodule

// File: rtl/tdm_slot_check.sv
module tdm_slot_check
  import flex_tdm_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int N_CH  = 24
) (
  input  slot_sel_t [SLOTS-1:0] cfg_i,
  output logic      [SLOTS-1:0] bad_o
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic used, idx_bad, bsel_bad, last_bad, ord_bad;

    assign used     = (cfg_i[i] != SLOT_IDLE);
    assign idx_bad  = (int'(cfg_i[i].chan) >= N_CH);
    assign bsel_bad = (cfg_i[i].bsel == BSEL_BAD);
    assign last_bad = (i == SLOTS - 1) && (cfg_i[i].bsel != BSEL_MS);

    // earlier slot of same channel must carry a strictly earlier byte
    always_comb begin
      ord_bad = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (cfg_i[j] != SLOT_IDLE &&
            cfg_i[j].chan == cfg_i[i].chan &&
            cfg_i[j].bsel >= cfg_i[i].bsel)
          ord_bad = 1'b1;
      end
    end

    assign bad_o[i] = used && (idx_bad || bsel_bad || last_bad || ord_bad);
  end
endmodule

// File: rtl/tdm_frame_ser.sv
module tdm_frame_ser
  import flex_tdm_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int N_CH  = 24,
  parameter int CH_W  = 24,
  localparam int FRAME_BITS = 8 * SLOTS,
  localparam int NB         = CH_W / 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   en_i,
  input  slot_sel_t [SLOTS-1:0]  cfg_i,
  input  logic      [SLOTS-1:0]  bad_i,
  input  logic [N_CH*CH_W-1:0]   chan_data_i,
  output logic                   sdata_o
);
  logic [FRAME_BITS-1:0] frame_w, sr_q;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [7:0]      byte_v;
    logic [CH_W-1:0] word_v;
    always_comb begin
      byte_v = '0;
      word_v = '0;
      if (en_i && !bad_i[k] && cfg_i[k] != SLOT_IDLE && int'(cfg_i[k].chan) < N_CH) begin
        word_v = chan_data_i[int'(cfg_i[k].chan)*CH_W +: CH_W];
        byte_v = 8'(word_v >> (8 * (NB - 1 - int'(cfg_i[k].bsel))));
      end
    end
    assign frame_w[FRAME_BITS-1-8*k -: 8] = byte_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (load_i) sr_q <= frame_w;
    else             sr_q <= {sr_q[FRAME_BITS-2:0], 1'b0};
  end

  assign sdata_o = sr_q[FRAME_BITS-1];
endmodule

// File: rtl/flex_tdm_mapper.sv
module flex_tdm_mapper
  import flex_tdm_pkg::*;
#(
  parameter int N_CH    = 24,
  parameter int CH_W    = 24,
  parameter int N_PORTS = 2,
  parameter int SLOTS   = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 cfg_we_i,
  input  logic [$clog2(N_PORTS*SLOTS/2)-1:0]   cfg_addr_i,
  input  logic [15:0]                          cfg_wdata_i,
  input  logic [2*N_PORTS-1:0]                 wl_sel_i,
  input  logic [N_CH*CH_W-1:0]                 chan_data_i,
  input  logic                                 fsync_i,
  output logic [N_PORTS-1:0]                   sdata_o,
  output logic                                 config_error_o
);
  localparam int N_SLOT_TOT = N_PORTS * SLOTS;
  localparam int N_PAIRS    = N_SLOT_TOT / 2;

  slot_sel_t [N_SLOT_TOT-1:0] slot_cfg;
  logic      [N_PORTS-1:0]    port_err;
  logic                       err_q;

  tdm_slot_cfg #(.N_PAIRS(N_PAIRS)) u_cfg (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .slot_cfg_o(slot_cfg)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic             flex;
    logic [SLOTS-1:0] bad;

    assign flex = (wl_sel_i[2*p +: 2] == WL_FLEX);

    tdm_slot_check #(.SLOTS(SLOTS), .N_CH(N_CH)) u_chk (
      .cfg_i(slot_cfg[p*SLOTS +: SLOTS]),
      .bad_o(bad)
    );

    tdm_frame_ser #(.SLOTS(SLOTS), .N_CH(N_CH), .CH_W(CH_W)) u_ser (
      .clk_i, .rst_ni,
      .load_i     (fsync_i),
      .en_i       (flex),
      .cfg_i      (slot_cfg[p*SLOTS +: SLOTS]),
      .bad_i      (bad),
      .chan_data_i,
      .sdata_o    (sdata_o[p])
    );

    assign port_err[p] = flex && (|bad);
  end

  // error sampled with the frame load, held until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (fsync_i) err_q <= err_q | (|port_err);
  end

  assign config_error_o = err_q;
endmodule

// File: rtl/flex_tdm_mapper_chk.sv
module flex_tdm_mapper_chk #(
  parameter int N_PORTS    = 2,
  parameter int FRAME_BITS = 256,
  localparam int CW = $clog2(FRAME_BITS + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 fsync_i,
  input logic [2*N_PORTS-1:0] wl_sel_i,
  input logic [N_PORTS-1:0]   sdata_o,
  input logic                 config_error_o
);
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              idle_cnt <= CW'(FRAME_BITS);
    else if (fsync_i)                         idle_cnt <= '0;
    else if (idle_cnt < CW'(FRAME_BITS))      idle_cnt <= idle_cnt + 1'b1;
  end

  AST_FRAME_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cnt == CW'(FRAME_BITS)) |-> (sdata_o == '0)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    config_error_o |=> config_error_o); // R10

  AST_ERR_AT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(config_error_o) |-> $past(fsync_i)); // R10

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    AST_NONFLEX_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fsync_i && wl_sel_i[2*p +: 2] != 2'b11) |=> !sdata_o[p]); // R6
  end
endmodule

bind flex_tdm_mapper flex_tdm_mapper_chk #(
  .N_PORTS   (N_PORTS),
  .FRAME_BITS(8 * SLOTS)
) u_mapper_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fsync_i       (fsync_i),
  .wl_sel_i      (wl_sel_i),
  .sdata_o       (sdata_o),
  .config_error_o(config_error_o)
);

// File: tb/sim_flex_tdm_mapper.sv
module sim_flex_tdm_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 24;

  typedef struct packed {
    logic [4:0]  pair;
    logic [15:0] word;
    logic [5:0]  gslot;
    logic [7:0]  exp;
  } vec_t;

  // legal layouts, cumulative; channel c bytes are MS=A0+c, M=50+c, LS=c
  localparam vec_t VECS [8] = '{
    '{5'd0,  16'h1514, 6'd0,  8'hA5},  // R1 R2 low byte, ch5 MS
    '{5'd0,  16'h1514, 6'd1,  8'h55},  // R1 R2 high byte, ch5 M
    '{5'd3,  16'hFF16, 6'd6,  8'h05},  // R8 gap before ch5 LS
    '{5'd3,  16'hFF16, 6'd7,  8'h00},  // R5 unused half
    '{5'd16, 16'h005C, 6'd32, 8'hB7},  // R1 port1 slot0, ch23 MS
    '{5'd16, 16'h005C, 6'd33, 8'hA0},  // R3 port1 slot1, ch0 MS
    '{5'd31, 16'h1C2A, 6'd63, 8'hA7},  // R9 MS allowed in last slot
    '{5'd15, 16'h0805, 6'd30, 8'h51}   // R2 ch1 M
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [3:0] wl = 4'hF;
  logic [N_CH*24-1:0] chan_data, base;
  logic fsync = 1'b0;
  logic [1:0] sdata;
  logic err;

  logic [7:0] got [2][32];
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flex_tdm_mapper u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .wl_sel_i(wl), .chan_data_i(chan_data),
    .fsync_i(fsync), .sdata_o(sdata), .config_error_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_frame(input int mut_at);
    @(negedge clk); fsync = 1'b1;
    @(negedge clk); fsync = 1'b0;
    for (int n = 0; n < 256; n++) begin
      if (n == mut_at) chan_data = ~base;
      got[0][n/8][7-(n%8)] = sdata[0];
      got[1][n/8][7-(n%8)] = sdata[1];
      @(negedge clk);
    end
    chan_data = base;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < N_CH; c++)
      base[c*24 +: 24] = {8'hA0 + 8'(c), 8'h50 + 8'(c), 8'(c)};
    chan_data = base;
    repeat (3) @(negedge clk);
    chk("R10 reset error flag", 32'(err), 0);
    chk("R5 reset output", 32'(sdata), 0);
    rst_n = 1'b1;

    // R1 R2 R3 table walk
    foreach (VECS[i]) begin
      wr(VECS[i].pair, VECS[i].word);
      run_frame(-1);
      chk($sformatf("R3 vector %0d slot %0d", i, VECS[i].gslot),
          32'(got[VECS[i].gslot / 32][VECS[i].gslot % 32]), 32'(VECS[i].exp));
    end
    chk("R5 unwritten slot 10 zero", 32'(got[0][10]), 0);
    chk("R2 ch10 LS in slot 62", 32'(got[1][30]), 32'h0A);
    chk("R8 legal gaps raise no error", 32'(err), 0);

    // R4 drain after 256 bits
    begin
      logic any = 1'b0;
      for (int n = 0; n < 8; n++) begin any |= |sdata; @(negedge clk); end
      chk("R4 zero after frame", 32'(any), 0);
    end

    // R11 bank change after load
    run_frame(4);
    chk("R11 slot0 unchanged", 32'(got[0][0]), 32'hA5);
    chk("R11 slot33 unchanged", 32'(got[1][1]), 32'hA0);

    // R4 restart mid-frame
    @(negedge clk); fsync = 1'b1;
    @(negedge clk); fsync = 1'b0;
    repeat (37) @(negedge clk);
    run_frame(-1);
    chk("R4 restart slot0", 32'(got[0][0]), 32'hA5);
    chk("R4 restart slot31", 32'(got[0][31]), 32'hA2);

    // R6 port1 non-flex
    wl = 4'b0011;
    run_frame(-1);
    chk("R6 port1 silent", 32'(got[1][0]), 0);
    chk("R6 port0 still flex", 32'(got[0][0]), 32'hA5);
    wl = 4'hF;

    // R7 channel index out of range
    wr(5'd4, 16'hFF78);
    chk("R10 no error before load", 32'(err), 0);
    run_frame(-1);
    chk("R7 bad index slot zero", 32'(got[0][8]), 0);
    chk("R7 bad index error", 32'(err), 1);
    wr(5'd4, 16'hFFFF);
    run_frame(-1);
    chk("R10 error sticky", 32'(err), 1);

    do_reset();
    chk("R10 error cleared by reset", 32'(err), 0);
    chk("R5 output zero after reset", 32'(sdata), 0);

    // R8 order violation
    wr(5'd5, 16'h0C0D);
    run_frame(-1);
    chk("R8 earlier slot kept", 32'(got[0][10]), 32'h53);
    chk("R8 later slot zero", 32'(got[0][11]), 0);
    chk("R8 order error", 32'(err), 1);
    do_reset();

    // R8 byte select 11
    wr(5'd6, 16'hFF0F);
    run_frame(-1);
    chk("R8 bsel 11 slot zero", 32'(got[0][12]), 0);
    chk("R8 bsel 11 error", 32'(err), 1);
    do_reset();

    // R9 multi-byte in last slot
    wr(5'd15, 16'h11FF);
    run_frame(-1);
    chk("R9 last slot zero", 32'(got[0][31]), 0);
    chk("R9 last slot error", 32'(err), 1);
    do_reset();

    // R6 bad config on non-flex port is not an error
    wl = 4'b0011;
    wr(5'd16, 16'hFF78);
    run_frame(-1);
    chk("R6 non-flex no error", 32'(err), 0);
    wl = 4'hF;
    run_frame(-1);
    chk("R6 flex error", 32'(err), 1);
    chk("R7 port1 bad slot zero", 32'(got[1][0]), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule